// File: doc/BRIEF.md
# Register Rename Map Table

This block renames one instruction per cycle. It takes the logical register numbers of two sources and one optional destination. It looks up the physical tags that the two sources map to at that moment. For a destination write, it takes the lowest-numbered free physical register, points the destination's map entry at that register, and reports the tag that the entry held before. A reorder stage outside the block keeps that old tag with the instruction.

When the instruction retires, the outside logic sends it back in program order on the commit port. Commit returns the old tag to the free list and records the new mapping in a committed copy of the map. A flush discards all speculative renaming: the speculative map is reloaded from the committed copy, and the free list is rebuilt as every physical register that the committed copy does not reference.

Sizes are parameters; the defaults are 8 logical and 16 physical registers. All rename results come out of registers one cycle after the request is accepted. The stall flag is derived directly from the free-list register.

Top module: `reg_rename_unit`

## Requirements
- R1: After reset, logical register i maps to physical tag i. Physical tags 8 to 15 are free, the stall output is low and the result-valid output is low.
- R2: An accepted request sets the result-valid output high on the clock edge that follows. On the same edge, each source tag output carries the physical tag that its logical register maps to in the cycle of the request.
- R3: A destination write gets the lowest-numbered free physical tag. That tag is removed from the free list and becomes the destination's mapping. It always differs from the old tag reported with it.
- R4: The old-tag output is the mapping the destination held before the request. A source that names the same logical register as the destination reads that old mapping.
- R5: While the free list is empty, the stall output is high. A request in that state is dropped: result-valid stays low, and neither the map nor the free list changes.
- R6: Logical register 0 always maps to physical tag 0. A write to register 0 allocates nothing, and its destination and old-tag outputs read 0 with the allocate flag low.
- R7: A tag displaced from the map stays out of the free list until a commit returns it, even if every free tag has been used up.
- R8: A commit with a nonzero destination returns its old tag to the free list and records its new tag as the committed mapping of that destination.
- R9: A flush copies the committed map into the speculative map. It rebuilds the free list as exactly the tags that the committed map does not reference.
- R10: A request accepted in the cycle right after an earlier one sees the earlier one's destination mapping, with no wait cycles.
- R11: A rename request in the same cycle as a flush is dropped, and result-valid is low after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid_i | input | 1 | Rename request present |
| ren_src0_i | input | LW | Logical number of source 0 |
| ren_src1_i | input | LW | Logical number of source 1 |
| ren_wr_i | input | 1 | Request writes a destination |
| ren_dst_i | input | LW | Logical number of the destination |
| cmt_valid_i | input | 1 | Commit of the oldest renamed write |
| cmt_dst_i | input | LW | Logical destination of the retiring write |
| cmt_new_tag_i | input | PW | Tag allocated to the retiring write |
| cmt_old_tag_i | input | PW | Tag the retiring write displaced |
| flush_i | input | 1 | Restore the map to the committed state |
| stall_o | output | 1 | Free list empty; requests are dropped |
| out_valid_o | output | 1 | Rename result present |
| out_alloc_o | output | 1 | Result carries a fresh destination tag |
| src0_tag_o | output | PW | Physical tag of source 0 |
| src1_tag_o | output | PW | Physical tag of source 1 |
| dst_tag_o | output | PW | Newly allocated physical tag |
| old_tag_o | output | PW | Displaced physical tag of the destination |

## Verification
The assertions assume that commits arrive in program order and carry the tags the block returned for that write. They also assume that no commit is sent in the same cycle as a flush, and that only writes actually renamed are ever committed. The bench keeps its own queue of allocating results and retires only from its head, with the tags it captured. It drives flush and commit in separate cycles and drops the queue at each flush. All expected tags come from a small model of map, committed map and free set that follows the requirements.

// File: rtl/rnm_pkg.sv
package rnm_pkg;
  // default geometry shared by the rename blocks and their bench
  parameter int DEF_LOG_REGS  = 8;
  parameter int DEF_PHYS_REGS = 16;

  // operation chosen for the free list in a cycle
  typedef enum logic [1:0] {
    FL_HOLD    = 2'd0,
    FL_UPDATE  = 2'd1,
    FL_REBUILD = 2'd2
  } fl_op_e;
endpackage

// File: rtl/rnm_free_list.sv
module rnm_free_list #(
  parameter int LOG_REGS  = rnm_pkg::DEF_LOG_REGS,
  parameter int PHYS_REGS = rnm_pkg::DEF_PHYS_REGS,
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  rnm_pkg::fl_op_e      op_i,
  input  logic                 take_i,
  input  logic                 give_i,
  input  logic [PW-1:0]        give_tag_i,
  input  logic [PHYS_REGS-1:0] used_i,
  output logic [PW-1:0]        grant_tag_o,
  output logic                 empty_o
);
  localparam logic [PHYS_REGS-1:0] RESET_FREE = {PHYS_REGS{1'b1}} << LOG_REGS;

  logic [PHYS_REGS-1:0] free_q;
  logic [PHYS_REGS-1:0] free_d;
  logic [PW-1:0]        grant;

  // lowest-numbered free tag wins
  always_comb begin
    grant = '0;
    for (int i = PHYS_REGS - 1; i >= 0; i--) begin
      if (free_q[i]) grant = PW'(i);
    end
  end

  always_comb begin
    free_d = free_q;
    case (op_i)
      rnm_pkg::FL_REBUILD: free_d = ~used_i;
      rnm_pkg::FL_UPDATE: begin
        if (take_i && !empty_o) free_d[grant] = 1'b0;
        if (give_i) free_d[give_tag_i] = 1'b1;
      end
      default: free_d = free_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) free_q <= RESET_FREE;
    else     free_q <= free_d;
  end

  assign grant_tag_o = grant;
  assign empty_o     = ~|free_q;
endmodule

// File: rtl/rnm_spec_map.sv
module rnm_spec_map #(
  parameter int LOG_REGS  = rnm_pkg::DEF_LOG_REGS,
  parameter int PHYS_REGS = rnm_pkg::DEF_PHYS_REGS,
  localparam int LW = $clog2(LOG_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic [LW-1:0]                rd0_idx_i,
  input  logic [LW-1:0]                rd1_idx_i,
  input  logic [LW-1:0]                rd2_idx_i,
  output logic [PW-1:0]                rd0_tag_o,
  output logic [PW-1:0]                rd1_tag_o,
  output logic [PW-1:0]                rd2_tag_o,
  input  logic                         wr_en_i,
  input  logic [LW-1:0]                wr_idx_i,
  input  logic [PW-1:0]                wr_tag_i,
  input  logic                         restore_i,
  input  logic [LOG_REGS-1:0][PW-1:0]  restore_map_i
);
  logic [LOG_REGS-1:0][PW-1:0] map_q;

  // reads see the map as it stands before this cycle's write
  assign rd0_tag_o = map_q[rd0_idx_i];
  assign rd1_tag_o = map_q[rd1_idx_i];
  assign rd2_tag_o = map_q[rd2_idx_i];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LOG_REGS; i++) map_q[i] <= PW'(i);
    end else if (restore_i) begin
      map_q <= restore_map_i;
    end else if (wr_en_i) begin
      map_q[wr_idx_i] <= wr_tag_i;
    end
  end
endmodule

// File: rtl/rnm_commit_map.sv
module rnm_commit_map #(
  parameter int LOG_REGS  = rnm_pkg::DEF_LOG_REGS,
  parameter int PHYS_REGS = rnm_pkg::DEF_PHYS_REGS,
  localparam int LW = $clog2(LOG_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         cmt_en_i,
  input  logic [LW-1:0]                cmt_idx_i,
  input  logic [PW-1:0]                cmt_tag_i,
  output logic [LOG_REGS-1:0][PW-1:0]  next_map_o,
  output logic [PHYS_REGS-1:0]         used_o
);
  logic [LOG_REGS-1:0][PW-1:0] cmap_q;
  logic [LOG_REGS-1:0][PW-1:0] cmap_d;

  always_comb begin
    cmap_d = cmap_q;
    if (cmt_en_i) cmap_d[cmt_idx_i] = cmt_tag_i;
  end

  // tags referenced by the committed state, including a same-cycle commit
  always_comb begin
    used_o = '0;
    for (int i = 0; i < LOG_REGS; i++) used_o[cmap_d[i]] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LOG_REGS; i++) cmap_q[i] <= PW'(i);
    end else begin
      cmap_q <= cmap_d;
    end
  end

  assign next_map_o = cmap_d;
endmodule

// File: rtl/reg_rename_unit.sv
module reg_rename_unit #(
  parameter int LOG_REGS  = rnm_pkg::DEF_LOG_REGS,
  parameter int PHYS_REGS = rnm_pkg::DEF_PHYS_REGS,
  localparam int LW = $clog2(LOG_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          ren_valid_i,
  input  logic [LW-1:0] ren_src0_i,
  input  logic [LW-1:0] ren_src1_i,
  input  logic          ren_wr_i,
  input  logic [LW-1:0] ren_dst_i,
  input  logic          cmt_valid_i,
  input  logic [LW-1:0] cmt_dst_i,
  input  logic [PW-1:0] cmt_new_tag_i,
  input  logic [PW-1:0] cmt_old_tag_i,
  input  logic          flush_i,
  output logic          stall_o,
  output logic          out_valid_o,
  output logic          out_alloc_o,
  output logic [PW-1:0] src0_tag_o,
  output logic [PW-1:0] src1_tag_o,
  output logic [PW-1:0] dst_tag_o,
  output logic [PW-1:0] old_tag_o
);
  logic                        empty;
  logic [PW-1:0]               grant_tag;
  logic [PW-1:0]               rd0_tag, rd1_tag, prev_tag;
  logic                        accept, do_alloc, do_commit;
  logic [LOG_REGS-1:0][PW-1:0] cmap_next;
  logic [PHYS_REGS-1:0]        cmap_used;
  rnm_pkg::fl_op_e             fl_op;

  // register 0 is pinned, so neither renames nor commits touch it
  assign accept    = ren_valid_i && !empty && !flush_i;
  assign do_alloc  = accept && ren_wr_i && (ren_dst_i != '0);
  assign do_commit = cmt_valid_i && (cmt_dst_i != '0);
  assign fl_op     = flush_i ? rnm_pkg::FL_REBUILD : rnm_pkg::FL_UPDATE;

  rnm_free_list #(.LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS)) free_i (
    .clk        (clk),
    .rst        (rst),
    .op_i       (fl_op),
    .take_i     (do_alloc),
    .give_i     (do_commit),
    .give_tag_i (cmt_old_tag_i),
    .used_i     (cmap_used),
    .grant_tag_o(grant_tag),
    .empty_o    (empty)
  );

  rnm_spec_map #(.LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS)) map_i (
    .clk          (clk),
    .rst          (rst),
    .rd0_idx_i    (ren_src0_i),
    .rd1_idx_i    (ren_src1_i),
    .rd2_idx_i    (ren_dst_i),
    .rd0_tag_o    (rd0_tag),
    .rd1_tag_o    (rd1_tag),
    .rd2_tag_o    (prev_tag),
    .wr_en_i      (do_alloc),
    .wr_idx_i     (ren_dst_i),
    .wr_tag_i     (grant_tag),
    .restore_i    (flush_i),
    .restore_map_i(cmap_next)
  );

  rnm_commit_map #(.LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS)) cmap_i (
    .clk       (clk),
    .rst       (rst),
    .cmt_en_i  (do_commit),
    .cmt_idx_i (cmt_dst_i),
    .cmt_tag_i (cmt_new_tag_i),
    .next_map_o(cmap_next),
    .used_o    (cmap_used)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid_o <= 1'b0;
      out_alloc_o <= 1'b0;
      src0_tag_o  <= '0;
      src1_tag_o  <= '0;
      dst_tag_o   <= '0;
      old_tag_o   <= '0;
    end else begin
      out_valid_o <= accept;
      out_alloc_o <= do_alloc;
      if (accept) begin
        src0_tag_o <= rd0_tag;
        src1_tag_o <= rd1_tag;
        dst_tag_o  <= do_alloc ? grant_tag : '0;
        old_tag_o  <= do_alloc ? prev_tag : '0;
      end
    end
  end

  assign stall_o = empty;
endmodule

// File: rtl/reg_rename_unit_chk.sv
module reg_rename_unit_chk #(
  parameter int LOG_REGS  = rnm_pkg::DEF_LOG_REGS,
  parameter int PHYS_REGS = rnm_pkg::DEF_PHYS_REGS,
  localparam int LW = $clog2(LOG_REGS),
  localparam int PW = $clog2(PHYS_REGS)
) (
  input logic          clk,
  input logic          rst,
  input logic          ren_valid_i,
  input logic [LW-1:0] ren_src0_i,
  input logic          cmt_valid_i,
  input logic          flush_i,
  input logic          stall_o,
  input logic          out_valid_o,
  input logic          out_alloc_o,
  input logic [PW-1:0] src0_tag_o,
  input logic [PW-1:0] dst_tag_o,
  input logic [PW-1:0] old_tag_o
);
  p_accept_valid_r2: assert property (@(posedge clk) disable iff (rst)
    (ren_valid_i && !stall_o && !flush_i) |=> out_valid_o);

  p_fresh_tag_r3: assert property (@(posedge clk) disable iff (rst)
    out_alloc_o |-> (dst_tag_o != old_tag_o));

  p_stall_drop_r5: assert property (@(posedge clk) disable iff (rst)
    (ren_valid_i && stall_o) |=> !out_valid_o);

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (stall_o && !cmt_valid_i && !flush_i) |=> stall_o);

  p_zero_src_r6: assert property (@(posedge clk) disable iff (rst)
    (ren_valid_i && !stall_o && !flush_i && ren_src0_i == '0) |=> (src0_tag_o == '0));

  p_zero_never_alloc_r6: assert property (@(posedge clk) disable iff (rst)
    out_alloc_o |-> (dst_tag_o != '0));

  p_flush_drop_r11: assert property (@(posedge clk) disable iff (rst)
    flush_i |=> !out_valid_o);
endmodule

bind reg_rename_unit reg_rename_unit_chk #(.LOG_REGS(LOG_REGS), .PHYS_REGS(PHYS_REGS)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .ren_valid_i(ren_valid_i),
  .ren_src0_i (ren_src0_i),
  .cmt_valid_i(cmt_valid_i),
  .flush_i    (flush_i),
  .stall_o    (stall_o),
  .out_valid_o(out_valid_o),
  .out_alloc_o(out_alloc_o),
  .src0_tag_o (src0_tag_o),
  .dst_tag_o  (dst_tag_o),
  .old_tag_o  (old_tag_o)
);

// File: tb/reg_rename_unit_tb_top.sv
module reg_rename_unit_tb_top;
  localparam int NL = 8;
  localparam int NP = 16;
  localparam int LW = $clog2(NL);
  localparam int PW = $clog2(NP);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic          ren_valid_i = 1'b0;
  logic [LW-1:0] ren_src0_i = '0, ren_src1_i = '0, ren_dst_i = '0;
  logic          ren_wr_i = 1'b0;
  logic          cmt_valid_i = 1'b0;
  logic [LW-1:0] cmt_dst_i = '0;
  logic [PW-1:0] cmt_new_tag_i = '0, cmt_old_tag_i = '0;
  logic          flush_i = 1'b0;
  logic          stall_o, out_valid_o, out_alloc_o;
  logic [PW-1:0] src0_tag_o, src1_tag_o, dst_tag_o, old_tag_o;

  always #4 clk = ~clk;

  reg_rename_unit #(.LOG_REGS(NL), .PHYS_REGS(NP)) dut_i (.*);

  int checks = 0;
  int errors = 0;

  // bench model of the requirements
  int m_map [NL];
  int m_cmap[NL];
  bit m_free[NP];
  // allocating results waiting to retire, oldest first
  int q_dst[64], q_new[64], q_old[64];
  int q_head = 0, q_tail = 0;

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic int model_lowest_free();
    for (int i = 0; i < NP; i++) if (m_free[i]) return i;
    return -1;
  endfunction

  // inputs change 1 time unit after a rising edge; outputs sampled there too
  task automatic rename(string req, int s0, int s1, int dst, bit wr);
    int e_valid, e_alloc, e_new, e_old, e_s0, e_s1;
    e_valid = (model_lowest_free() >= 0);
    e_s0 = m_map[s0];
    e_s1 = m_map[s1];
    e_alloc = e_valid && wr && (dst != 0);
    e_new = e_alloc ? model_lowest_free() : 0;
    e_old = e_alloc ? m_map[dst] : 0;
    ren_valid_i = 1'b1;
    ren_src0_i = LW'(s0);
    ren_src1_i = LW'(s1);
    ren_dst_i = LW'(dst);
    ren_wr_i = wr;
    @(posedge clk); #1;
    ren_valid_i = 1'b0;
    chk(req, "out_valid", int'(out_valid_o), e_valid);
    if (e_valid != 0) begin
      chk(req, "src0_tag", int'(src0_tag_o), e_s0);
      chk(req, "src1_tag", int'(src1_tag_o), e_s1);
      chk(req, "alloc", int'(out_alloc_o), e_alloc);
      chk(req, "dst_tag", int'(dst_tag_o), e_new);
      chk(req, "old_tag", int'(old_tag_o), e_old);
    end
    if (e_alloc != 0) begin
      m_free[e_new] = 1'b0;
      m_map[dst] = e_new;
      q_dst[q_tail] = dst; q_new[q_tail] = e_new; q_old[q_tail] = e_old;
      q_tail++;
    end
  endtask

  task automatic commit_oldest();
    cmt_valid_i = 1'b1;
    cmt_dst_i = LW'(q_dst[q_head]);
    cmt_new_tag_i = PW'(q_new[q_head]);
    cmt_old_tag_i = PW'(q_old[q_head]);
    @(posedge clk); #1;
    cmt_valid_i = 1'b0;
    m_cmap[q_dst[q_head]] = q_new[q_head];
    m_free[q_old[q_head]] = 1'b1;
    q_head++;
  endtask

  task automatic model_flush();
    for (int i = 0; i < NP; i++) m_free[i] = 1'b1;
    for (int i = 0; i < NL; i++) begin
      m_map[i] = m_cmap[i];
      m_free[m_cmap[i]] = 1'b0;
    end
    q_head = 0; q_tail = 0;
  endtask

  // R1: reset mapping and free set
  task automatic t_reset();
    chk("R1", "stall after reset", int'(stall_o), 0);
    chk("R1", "valid after reset", int'(out_valid_o), 0);
    rename("R1", 3, 7, 0, 1'b0);
    rename("R2", 5, 6, 0, 1'b0);
  endtask

  // R3, R4, R10: allocation, old tag, back-to-back dependence
  task automatic t_basic();
    rename("R4", 1, 2, 1, 1'b1);        // src0 reads old tag 1, gets tag 8
    chk("R3", "first tag", int'(dst_tag_o), 8);
    rename("R10", 1, 1, 2, 1'b1);       // sees tag 8 one cycle later
    chk("R10", "dependent src", int'(src0_tag_o), 8);
  endtask

  // R6: register 0 is pinned
  task automatic t_zero();
    rename("R6", 0, 0, 0, 1'b1);
    chk("R6", "no alloc for r0", int'(out_alloc_o), 0);
    rename("R6", 0, 2, 3, 1'b1);
    chk("R6", "next tag unchanged by r0 write", int'(dst_tag_o), 10);
  endtask

  // R5, R7: exhaust the free list, displaced tags stay out
  task automatic t_exhaust();
    rename("R7", 4, 3, 4, 1'b1);
    rename("R7", 5, 4, 5, 1'b1);
    rename("R7", 6, 5, 6, 1'b1);
    rename("R7", 7, 6, 7, 1'b1);
    rename("R7", 1, 7, 1, 1'b1);
    chk("R7", "stall with displaced tags held", int'(stall_o), 1);
    rename("R5", 1, 2, 2, 1'b1);        // dropped
    chk("R5", "stall held", int'(stall_o), 1);
  endtask

  // R8: commit returns the old tag
  task automatic t_commit();
    commit_oldest();                    // returns tag 1
    chk("R8", "stall released", int'(stall_o), 0);
    rename("R8", 1, 2, 2, 1'b1);        // gets tag 1; src0 shows map unchanged by drop
    chk("R8", "reused tag", int'(dst_tag_o), 1);
    chk("R5", "map unchanged by dropped request", int'(src0_tag_o), 15);
    commit_oldest();
  endtask

  // R9: flush restores committed state
  task automatic t_flush();
    flush_i = 1'b1;
    @(posedge clk); #1;
    flush_i = 1'b0;
    model_flush();
    chk("R9", "stall after flush", int'(stall_o), 0);
    rename("R9", 1, 2, 3, 1'b1);
    chk("R9", "committed map src", int'(src0_tag_o), 8);
    chk("R9", "rebuilt free list", int'(dst_tag_o), 1);
  endtask

  // R11: flush drops a same-cycle rename
  task automatic t_flush_rename();
    ren_valid_i = 1'b1; ren_wr_i = 1'b1;
    ren_src0_i = 3'd4; ren_src1_i = 3'd5; ren_dst_i = 3'd4;
    flush_i = 1'b1;
    @(posedge clk); #1;
    flush_i = 1'b0; ren_valid_i = 1'b0;
    model_flush();
    chk("R11", "valid with flush", int'(out_valid_o), 0);
    rename("R11", 3, 4, 4, 1'b1);
    chk("R11", "r4 not renamed by dropped request", int'(src1_tag_o), 4);
  endtask

  initial begin
    for (int i = 0; i < NL; i++) begin m_map[i] = i; m_cmap[i] = i; end
    for (int i = 0; i < NP; i++) m_free[i] = (i >= NL);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_basic();
    t_zero();
    t_exhaust();
    t_commit();
    t_flush();
    t_flush_rename();
    repeat (2) @(posedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R1 watchdog actual=expired expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule